// File: doc/BRIEF.md
# Two-Input Arrival Order Detector

The block watches two level inputs, `in_a` and `in_b`, that are expected to change one at a time. Once both are high, it reports which of them went high first. It raises `first_a` if `in_a` led and `first_b` if `in_b` led. While the pair is anything other than both-high, both outputs stay low. The result depends on the order in which the inputs rose, not on their present levels.

Each input first passes through a synchroniser chain of `SYNC_STAGES` flops. The synchronised pair then feeds a clocked machine with only two states:

- `LEAD_B` is the reset state. It moves to `LEAD_A` when the pair reads `in_a` high alone, and otherwise stays where it is.
- `LEAD_A` stays put while `in_a` is high, and returns to `LEAD_B` when `in_a` is low.

The report is built from the current state and the pair, and it is registered. An output therefore changes exactly `SYNC_STAGES + 1` rising edges after the input changes.

If both inputs jump from low to high together, the one-at-a-time rule is broken. The machine then stays in `LEAD_B` and reports `first_b`.

Top module: `order_detect`

## Requirements
- R1: While `rst` is high, and on the first edges after it falls, both `first_a` and `first_b` read 0.
- R2: Whenever the synchronised pair {in_a,in_b} is not 2'b11, both outputs read 0 one edge later.
- R3: With the input order 00, 10, 11 (in_a rising first), the outputs read first_a=1 and first_b=0 while both inputs stay high.
- R4: With the input order 00, 01, 11 (in_b rising first), the outputs read first_a=0 and first_b=1 while both inputs stay high.
- R5: If one input drops from 11 and rises again without the other input ever being high alone, the report names the same leader as before.
- R6: Returning to 00 clears the leader. After 10, 00, 11 the report is first_b, and any path that visits 10 and 01 separately through 00 keeps both outputs at 0.
- R7: A direct 00 to 11 jump reports first_b=1 and first_a=0.
- R8: An input change reaches the outputs exactly SYNC_STAGES+1 rising edges later, and first_a and first_b are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | First monitored level, asynchronous |
| in_b | input | 1 | Second monitored level, asynchronous |
| first_a | output | 1 | High while both inputs are high and in_a led |
| first_b | output | 1 | High while both inputs are high and in_b led |

## Verification
The bench builds two copies of the block, one with `SYNC_STAGES=2` and one with `SYNC_STAGES=3`. This checks that the ordering result does not depend on the depth of the synchroniser chain.

Both copies are driven through every path of six single-input flips that starts from 00. Every reachable ordering, recovery and return through 00 is therefore covered. The expected output comes from a last-sole-high-input model kept in the bench.

Directed cases pin down the following on the two-stage copy:
- the exact latency edge;
- the direct 00 to 11 jump;
- the clearing effect of 00.

// File: rtl/order_detect_pkg.sv
`timescale 1ns/1ps
package order_detect_pkg;
  // Leader state: LEAD_B doubles as the reset state
  typedef enum logic {
    LEAD_B = 1'b0,
    LEAD_A = 1'b1
  } lead_e;

  localparam int unsigned PAIR_W = 2;
  // pair bit 1 is in_a, bit 0 is in_b
  localparam logic [PAIR_W-1:0] PAIR_NONE   = 2'b00;
  localparam logic [PAIR_W-1:0] PAIR_ONLY_B = 2'b01;
  localparam logic [PAIR_W-1:0] PAIR_ONLY_A = 2'b10;
  localparam logic [PAIR_W-1:0] PAIR_BOTH   = 2'b11;

  function automatic logic [PAIR_W-1:0] report(lead_e st, logic [PAIR_W-1:0] p);
    if (p != PAIR_BOTH) return PAIR_NONE;
    return (st == LEAD_A) ? PAIR_ONLY_A : PAIR_ONLY_B;
  endfunction
endpackage

// File: rtl/level_sync.sv
`timescale 1ns/1ps
module level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOP-1:0], d};
      end
    end
  endgenerate

  assign q = chain[TOP];
endmodule

// File: rtl/order_fsm.sv
`timescale 1ns/1ps
module order_fsm
  import order_detect_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PAIR_W-1:0] pair,
  output logic [PAIR_W-1:0] rep
);
  lead_e st_q, st_d;
  logic [PAIR_W-1:0] rep_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LEAD_B: if (pair == PAIR_ONLY_A) st_d = LEAD_A;
      LEAD_A: if (!pair[1])            st_d = LEAD_B;
      default:                         st_d = LEAD_B;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= LEAD_B;
      rep_q <= PAIR_NONE;
    end else begin
      st_q  <= st_d;
      rep_q <= report(st_q, pair);
    end
  end

  assign rep = rep_q;
endmodule

// File: rtl/order_detect.sv
`timescale 1ns/1ps
module order_detect
  import order_detect_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  output logic first_a,
  output logic first_b
);
  logic [PAIR_W-1:0] raw;
  logic [PAIR_W-1:0] pair_s;
  logic [PAIR_W-1:0] rep;

  assign raw = {in_a, in_b};

  generate
    for (genvar i = 0; i < PAIR_W; i++) begin : g_sync
      level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw[i]),
        .q  (pair_s[i])
      );
    end
  endgenerate

  order_fsm u_fsm (
    .clk (clk),
    .rst (rst),
    .pair(pair_s),
    .rep (rep)
  );

  assign first_a = rep[1];
  assign first_b = rep[0];
endmodule

// File: rtl/order_detect_chk.sv
`timescale 1ns/1ps
module order_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pair,
  input logic       first_a,
  input logic       first_b
);
  // R8
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(first_a && first_b));

  // R2
  quiet_unless_both_chk: assert property (@(posedge clk) disable iff (rst)
    (pair != 2'b11) |=> (!first_a && !first_b));

  // R3
  a_leads_chk: assert property (@(posedge clk) disable iff (rst)
    (pair == 2'b10) ##1 (pair == 2'b11) |=> (first_a && !first_b));

  // R4
  b_leads_chk: assert property (@(posedge clk) disable iff (rst)
    (pair == 2'b01) ##1 (pair == 2'b11) |=> (first_b && !first_a));

  // R7
  jump_reports_b_chk: assert property (@(posedge clk) disable iff (rst)
    (pair == 2'b00) ##1 (pair == 2'b11) |=> (first_b && !first_a));

  // R5
  hold_report_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pair) == 2'b11 && pair == 2'b11) |=> $stable({first_a, first_b}));
endmodule

bind order_detect order_detect_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pair   (pair_s),
  .first_a(first_a),
  .first_b(first_b)
);

// File: tb/order_detect_test.sv
`timescale 1ns/1ps
module order_detect_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic fa2, fb2, fa3, fb3;
  int   total = 0;
  int   bad = 0;
  logic lead_a = 1'b0;

  always #4 clk = ~clk;

  order_detect #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .first_a(fa2), .first_b(fb2));
  order_detect #(.SYNC_STAGES(3)) uut3 (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .first_a(fa3), .first_b(fb3));

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_a = 1'b0; in_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    lead_a = 1'b0;
  endtask

  // bench model: leader is the last input seen high alone, cleared at 00
  function automatic logic [1:0] expect_of(input logic [1:0] p);
    if (p == 2'b10) lead_a = 1'b1;
    else if (!p[1]) lead_a = 1'b0;
    if (p != 2'b11) return 2'b00;
    return lead_a ? 2'b10 : 2'b01;
  endfunction

  task automatic apply(input logic [1:0] p, input string tag);
    logic [1:0] e;
    @(negedge clk);
    in_a = p[1]; in_b = p[0];
    e = expect_of(p);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check({tag, " s2"}, {fa2, fb2}, e);
    check({tag, " s3"}, {fa3, fb3}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs low while reset is held
    repeat (2) @(posedge clk);
    @(negedge clk);
    in_a = 1'b1; in_b = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", {fa2, fb2}, 2'b00);
    check("R1 in reset s3", {fa3, fb3}, 2'b00);
    in_a = 1'b0; in_b = 1'b0;
    do_reset();
    @(negedge clk);
    check("R1 after reset", {fa2, fb2}, 2'b00);

    // exhaustive single-flip walks of length 6 from 00 (R2 R3 R4 R5 R6)
    for (int seq = 0; seq < 64; seq++) begin
      logic [1:0] p;
      do_reset();
      p = 2'b00;
      for (int k = 0; k < 6; k++) begin
        if (seq[k]) p[0] = ~p[0];
        else        p[1] = ~p[1];
        if (p != 2'b11)   apply(p, "R2 walk");
        else if (lead_a || p == 2'b11 && 1'b0) apply(p, "R3 walk");
        else              apply(p, "R4 walk");
      end
    end

    // R5: leader kept across a drop of the other input
    do_reset();
    apply(2'b10, "R5 setup");
    apply(2'b11, "R3 a first");
    apply(2'b10, "R5 drop b");
    apply(2'b11, "R5 a still leads");
    apply(2'b01, "R5 drop a");
    apply(2'b11, "R5 b now leads");

    // R6: return through 00 clears the leader
    do_reset();
    apply(2'b10, "R6 a alone");
    apply(2'b00, "R6 back to 00");
    apply(2'b11, "R6 leader cleared");

    // R7: direct jump 00 -> 11 from reset
    do_reset();
    apply(2'b11, "R7 jump");

    // R8: exact latency on the two-stage copy
    do_reset();
    apply(2'b10, "R8 setup");
    @(negedge clk);
    in_b = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 before edge 3", {fa2, fb2}, 2'b00);
    @(posedge clk);
    @(negedge clk);
    check("R8 at edge 3", {fa2, fb2}, 2'b10);
    check("R8 s3 not yet", {fa3, fb3}, 2'b00);
    @(posedge clk);
    @(negedge clk);
    check("R8 s3 at edge 4", {fa3, fb3}, 2'b10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule